// File: doc/BRIEF.md
# Chainable SPI Digital I/O Expander

This block is the serial front end of a multi-channel digital I/O device that several identical devices can share in one chain. The host pulls chip select low, which freezes the current input channel levels into a transmit shift register behind a status header. While chip select stays low, the device shifts that word out on SDO and takes a command word in from SDI. When chip select returns high, the last complete command word held in the device is carried out. Every device in a chain sees the same chip select, so all inputs are captured together and all outputs change together.

A command word is an 8-bit opcode followed by one data bit per channel. The command set covers these actions:
- write the channel outputs;
- pulse per-channel synchronisation strobes;
- start a background configuration transfer;
- read the output status register, or the input-change flags, in the data half of the frame that carries the opcode.

A startup monitor keeps the port silent until it is ready. At the end of a fixed window after reset, if chip select is still low, it takes a quickstart path. That path skips the configuration load and flags both CRC-error bits.

Top module: `spi_chain_io`

## Requirements
- R1: On the chip-select falling edge, taken while ready, the device loads the transmit word {header, din}. The header is 8 bits: bit 7 is 1, bit 6 is busy, bits 5:4 are the two CRC-error bits and bits 3:0 are 0. A change on din after that edge does not alter the word shifted out.
- R2: SPI mode 0 with the most significant bit first. SDI is taken on the rising SCLK edge. SDO shows the first bit once chip select has fallen, and after that SDO moves only on the falling SCLK edge.
- R3: dout changes only at a chip-select rising edge. It takes the data field when the held word's opcode is 0x01. A frame has 16 bits: opcode in bits 15:8 and channel data in bits 7:0.
- R4: With chip select held low across several frames, SDO repeats the SDI bits exactly 16 bits later. The command that is acted on is the last 16 bits received.
- R5: If chip select rises after a bit count that is zero or not a multiple of 16, the frame is dropped and no output or strobe changes.
- R6: While ready is 0, the port ignores SPI traffic: SDO stays 0 and dout is not written.
- R7: If chip select is high at the end of the startup window (BOOT_WINDOW cycles after reset release), ready rises LOAD_CYCLES cycles later and both CRC-error bits read 0. Once ready is set, it stays set until reset.
- R8: If chip select is low at the end of the window, ready rises on the very next cycle and both CRC-error bits read 1.
- R9: Opcode 0x02 replaces the data half of the same frame on SDO with the current dout value. Opcode 0x03 replaces it with the input-change flags, which then clear. A flag bit is set by any change of that din bit since the last read.
- R10: Opcode 0x10 drives the sync output with the data field for exactly one clock cycle.
- R11: Opcode 0x05 starts a background load. The busy header bit reads 1 for LOAD_CYCLES cycles, and the CRC-error bits clear when the load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, synchronous to clk |
| ncs | input | 1 | SPI chip select, active low |
| sdi | input | 1 | SPI serial data in |
| sdo | output | 1 | SPI serial data out, 0 when idle |
| din | input | NCH | Input channel levels |
| dout | output | NCH | Output channel levels |
| sync | output | NCH | One-cycle channel synchronisation strobes |
| ready | output | 1 | Startup complete, port enabled |

## Verification
The capture path is swept across every input pattern, and the write path across every output pattern followed by a status read-back. Together these separate faults in bit order, in snapshot timing and in the fast-read substitution. Chained transfers of two and three frames check the one-frame echo delay and confirm that only the last frame is executed. Frames of 15 and 17 bits show that rejection depends on the bit count. The two startup paths are run from separate resets and timed to the exact cycle, so they tell apart the window check, the load delay and the CRC flag setting. An input change in mid-frame and a sequence of change-flag reads separate the snapshot from live sampling and the read-to-clear behaviour from sticky flags.

// File: rtl/spi_io_pkg.sv
package spi_io_pkg;
    localparam int OPW = 8;

    localparam logic [OPW-1:0] OP_NOP     = 8'h00;
    localparam logic [OPW-1:0] OP_WRITE   = 8'h01;
    localparam logic [OPW-1:0] OP_RD_STAT = 8'h02;
    localparam logic [OPW-1:0] OP_RD_IRQ  = 8'h03;
    localparam logic [OPW-1:0] OP_LOAD    = 8'h05;
    localparam logic [OPW-1:0] OP_SYNC    = 8'h10;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } boot_state_e;
endpackage

// File: rtl/spi_startup.sv
module spi_startup
    import spi_io_pkg::*;
#(
    parameter int BOOT_WINDOW = 3750,
    parameter int LOAD_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ncs_i,
    input  logic       load_start_i,
    output logic       ready_o,
    output logic       busy_o,
    output logic [1:0] crc_err_o
);
    localparam int MAXC = (BOOT_WINDOW > LOAD_CYCLES) ? BOOT_WINDOW : LOAD_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WIN_LAST  = CW'(BOOT_WINDOW - 1);
    localparam logic [CW-1:0] LOAD_LAST = CW'(LOAD_CYCLES - 1);

    typedef struct packed {
        boot_state_e   state;
        logic [CW-1:0] cnt;
        logic          hbusy;
        logic [1:0]    crc;
    } boot_t;

    boot_t q, d;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_WAIT: begin
                if (q.cnt == WIN_LAST) begin
                    d.cnt = '0;
                    if (!ncs_i) begin
                        d.state = ST_RUN;
                        d.crc   = 2'b11;
                    end else begin
                        d.state = ST_LOAD;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_LOAD: begin
                if (q.cnt == LOAD_LAST) begin
                    d.cnt   = '0;
                    d.state = ST_RUN;
                    d.crc   = 2'b00;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                if (q.hbusy) begin
                    if (q.cnt == LOAD_LAST) begin
                        d.hbusy = 1'b0;
                        d.cnt   = '0;
                        d.crc   = 2'b00;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end else if (load_start_i) begin
                    d.hbusy = 1'b1;
                    d.cnt   = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_WAIT;
            q.cnt   <= '0;
            q.hbusy <= 1'b0;
            q.crc   <= 2'b00;
        end else begin
            q <= d;
        end
    end

    assign ready_o   = (q.state == ST_RUN);
    assign busy_o    = (q.state == ST_LOAD) || q.hbusy;
    assign crc_err_o = q.crc;

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o); // R7

    AST_QUICK_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RUN) && $past(q.state == ST_WAIT) |-> (q.crc == 2'b11) && !$past(ncs_i)); // R8
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_io_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_i,
    input  logic                 ncs_i,
    input  logic                 sdi_i,
    input  logic                 ready_i,
    input  logic [OPW-1:0]       hdr_i,
    input  logic [NCH-1:0]       din_i,
    input  logic [NCH-1:0]       stat_i,
    input  logic [NCH-1:0]       irq_i,
    output logic                 sdo_o,
    output logic                 irq_take_o,
    output logic                 done_o,
    output logic [OPW+NCH-1:0]   word_o
);
    localparam int FRAME = OPW + NCH;
    localparam int CW    = $clog2(FRAME);
    localparam logic [CW-1:0] BIT_LAST = CW'(FRAME - 1);
    localparam logic [CW-1:0] OP_LAST  = CW'(OPW - 1);

    typedef struct packed {
        logic             sclk;
        logic             ncs;
        logic             active;
        logic             first;
        logic             any;
        logic [CW-1:0]    bitcnt;
        logic [FRAME-1:0] sh;
        logic             sdo;
        logic             done;
        logic [FRAME-1:0] word;
    } shift_t;

    shift_t q, d;
    logic             ncs_fall, ncs_rise, sclk_rise, sclk_fall;
    logic [FRAME-1:0] shifted;
    logic [OPW-1:0]   opcode;

    always_comb begin
        d          = q;
        d.sclk     = sclk_i;
        d.ncs      = ncs_i;
        d.done     = 1'b0;
        irq_take_o = 1'b0;
        ncs_fall   = q.ncs & ~ncs_i;
        ncs_rise   = ~q.ncs & ncs_i;
        sclk_rise  = ~q.sclk & sclk_i;
        sclk_fall  = q.sclk & ~sclk_i;
        shifted    = {q.sh[FRAME-2:0], sdi_i};
        opcode     = {q.sh[OPW-2:0], sdi_i};

        if (ncs_fall && ready_i) begin
            d.active = 1'b1;
            d.first  = 1'b1;
            d.any    = 1'b0;
            d.bitcnt = '0;
            d.sh     = {hdr_i, din_i};
            d.sdo    = hdr_i[OPW-1];
        end else if (q.active) begin
            if (ncs_rise) begin
                d.active = 1'b0;
                d.sdo    = 1'b0;
                if (q.any && (q.bitcnt == '0)) begin
                    d.done = 1'b1;
                    d.word = q.sh;
                end
            end else begin
                if (sclk_rise) begin
                    d.any = 1'b1;
                    if (q.bitcnt == BIT_LAST) begin
                        d.bitcnt = '0;
                        d.first  = 1'b0;
                    end else begin
                        d.bitcnt = q.bitcnt + 1'b1;
                    end
                    if (q.first && (q.bitcnt == OP_LAST)) begin
                        if (opcode == OP_RD_STAT) begin
                            shifted[FRAME-1 -: NCH] = stat_i;
                        end else if (opcode == OP_RD_IRQ) begin
                            shifted[FRAME-1 -: NCH] = irq_i;
                            irq_take_o = 1'b1;
                        end
                    end
                    d.sh = shifted;
                end
                if (sclk_fall) begin
                    d.sdo = q.sh[FRAME-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sclk   <= 1'b0;
            q.ncs    <= 1'b1;
            q.active <= 1'b0;
            q.first  <= 1'b0;
            q.any    <= 1'b0;
            q.bitcnt <= '0;
            q.sh     <= '0;
            q.sdo    <= 1'b0;
            q.done   <= 1'b0;
            q.word   <= '0;
        end else begin
            q <= d;
        end
    end

    assign sdo_o  = q.sdo;
    assign done_o = q.done;
    assign word_o = q.word;

    AST_UNREADY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> !q.active && !q.sdo); // R6

    AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> q.ncs && !$past(q.ncs)); // R5
endmodule

// File: rtl/spi_io_regs.sv
module spi_io_regs
    import spi_io_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done_i,
    input  logic [OPW+NCH-1:0] word_i,
    input  logic               irq_take_i,
    input  logic [NCH-1:0]     din_i,
    output logic [NCH-1:0]     dout_o,
    output logic [NCH-1:0]     sync_o,
    output logic [NCH-1:0]     irq_o,
    output logic               load_start_o
);
    localparam int FRAME = OPW + NCH;

    typedef struct packed {
        logic [NCH-1:0] dout;
        logic [NCH-1:0] sync;
        logic [NCH-1:0] irq;
        logic [NCH-1:0] din_prev;
        logic           load;
    } regs_t;

    regs_t q, d;
    logic [OPW-1:0] op;
    logic [NCH-1:0] data;

    always_comb begin
        d          = q;
        op         = word_i[FRAME-1 -: OPW];
        data       = word_i[NCH-1:0];
        d.sync     = '0;
        d.load     = 1'b0;
        d.din_prev = din_i;
        d.irq      = (irq_take_i ? '0 : q.irq) | (din_i ^ q.din_prev);
        if (done_i) begin
            unique case (op)
                OP_WRITE: d.dout = data;
                OP_SYNC:  d.sync = data;
                OP_LOAD:  d.load = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.dout     <= '0;
            q.sync     <= '0;
            q.irq      <= '0;
            q.din_prev <= '0;
            q.load     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign dout_o       = q.dout;
    assign sync_o       = q.sync;
    assign irq_o        = q.irq;
    assign load_start_o = q.load;

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(dout_o)); // R3

    AST_SYNC_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|sync_o) |=> (sync_o == '0)); // R10
endmodule

// File: rtl/spi_chain_io.sv
module spi_chain_io
    import spi_io_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int BOOT_WINDOW = 3750,
    parameter int LOAD_CYCLES = 2000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk,
    input  logic           ncs,
    input  logic           sdi,
    output logic           sdo,
    input  logic [NCH-1:0] din,
    output logic [NCH-1:0] dout,
    output logic [NCH-1:0] sync,
    output logic           ready
);
    localparam int FRAME = OPW + NCH;

    logic             busy, load_start, done, irq_take;
    logic [1:0]       crc_err;
    logic [OPW-1:0]   hdr;
    logic [FRAME-1:0] word;
    logic [NCH-1:0]   irq_flags;

    assign hdr = {1'b1, busy, crc_err, {(OPW-4){1'b0}}};

    spi_startup #(
        .BOOT_WINDOW (BOOT_WINDOW),
        .LOAD_CYCLES (LOAD_CYCLES)
    ) u_startup (
        .clk          (clk),
        .rst_n        (rst_n),
        .ncs_i        (ncs),
        .load_start_i (load_start),
        .ready_o      (ready),
        .busy_o       (busy),
        .crc_err_o    (crc_err)
    );

    spi_shift_core #(
        .NCH (NCH)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk),
        .ncs_i      (ncs),
        .sdi_i      (sdi),
        .ready_i    (ready),
        .hdr_i      (hdr),
        .din_i      (din),
        .stat_i     (dout),
        .irq_i      (irq_flags),
        .sdo_o      (sdo),
        .irq_take_o (irq_take),
        .done_o     (done),
        .word_o     (word)
    );

    spi_io_regs #(
        .NCH (NCH)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_i       (done),
        .word_i       (word),
        .irq_take_i   (irq_take),
        .din_i        (din),
        .dout_o       (dout),
        .sync_o       (sync),
        .irq_o        (irq_flags),
        .load_start_o (load_start)
    );
endmodule

// File: tb/tb_spi_chain_io.sv
module tb_spi_chain_io;
    localparam int NCH = 8;
    localparam int W   = 200;
    localparam int L   = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic ncs = 1'b1;
    logic sdi = 1'b0;
    logic [NCH-1:0] din = '0;
    logic sdo, ready;
    logic [NCH-1:0] dout, sync;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int sync_cnt = 0;
    logic [NCH-1:0] sync_last = '0;
    bit finished = 0;

    always #4 clk = ~clk;

    spi_chain_io #(.NCH(NCH), .BOOT_WINDOW(W), .LOAD_CYCLES(L)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ncs(ncs), .sdi(sdi), .sdo(sdo),
        .din(din), .dout(dout), .sync(sync), .ready(ready)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (|sync) begin
            sync_cnt  <= sync_cnt + 1;
            sync_last <= sync;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [63:0] tx, input int nb, input int chg_bit,
                        input logic [NCH-1:0] chg_val, output logic [63:0] rx);
        rx = '0;
        @(negedge clk) ncs = 1'b0;
        @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            if (i == chg_bit) din = chg_val;
            rx   = {rx[62:0], sdo};
            sdi  = tx[nb-1-i];
            sclk = 1'b1;
            @(negedge clk);
            sclk = 1'b0;
            @(negedge clk);
        end
        ncs = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] rx;
        logic [NCH-1:0] prev;
        int c0;

        repeat (3) @(negedge clk);
        check(sdo == 1'b0 && dout == '0 && ready == 1'b0, "R6 reset state", {sdo, ready, dout}, 0);
        rst_n = 1'b1;

        // R6: traffic during startup is ignored
        xfer({48'h0, 16'h01FF}, 16, -1, '0, rx);
        check(rx[15:0] == 16'h0000, "R6 sdo idle while not ready", rx, 0);
        check(dout == '0, "R6 dout untouched while not ready", dout, 0);

        // R7: normal startup timing
        while (cyc < W + L - 1) @(negedge clk);
        check(ready == 1'b0, "R7 not ready one cycle early", ready, 0);
        @(negedge clk);
        check(ready == 1'b1, "R7 ready after window plus load", ready, 1);
        xfer(64'h0, 16, -1, '0, rx);
        check(rx[15:8] == 8'h80, "R7 header crc clear after normal start", rx[15:8], 8'h80);

        // R1/R2: capture sweep over every input pattern
        for (int v = 0; v < 256; v++) begin
            din = NCH'(v);
            repeat (2) @(negedge clk);
            xfer(64'h0, 16, -1, '0, rx);
            check(rx[15:0] == {8'h80, 8'(v)}, "R1 R2 snapshot msb first", rx[15:0], {8'h80, 8'(v)});
        end

        // R1: input change in mid-frame is not seen
        din = 8'h3C;
        repeat (2) @(negedge clk);
        xfer(64'h0, 16, 4, 8'hC3, rx);
        check(rx[15:0] == 16'h803C, "R1 mid-frame din change ignored", rx[15:0], 16'h803C);
        xfer(64'h0, 16, -1, '0, rx);
        check(rx[7:0] == 8'hC3, "R1 next snapshot sees new din", rx[7:0], 8'hC3);

        // R3/R9: write sweep and status read-back
        for (int v = 0; v < 256; v++) begin
            xfer({48'h0, 8'h01, 8'(v)}, 16, -1, '0, rx);
            check(dout == 8'(v), "R3 write applied at chip select rise", dout, v);
            xfer({48'h0, 8'h02, 8'h00}, 16, -1, '0, rx);
            check(rx[7:0] == 8'(v), "R9 fast status read", rx[7:0], v);
            check(dout == 8'(v), "R3 read opcode leaves dout", dout, v);
        end

        // R4: two- and three-frame chains
        xfer({32'h0, 16'h013C, 16'h015A}, 32, -1, '0, rx);
        check(rx[15:0] == 16'h013C, "R4 sdi echoed one frame later", rx[15:0], 16'h013C);
        check(dout == 8'h5A, "R4 last frame executed", dout, 8'h5A);
        xfer({16'h0, 16'h0111, 16'h0122, 16'h0133}, 48, -1, '0, rx);
        check(rx[31:0] == 32'h01110122, "R4 three-frame echo", rx[31:0], 32'h01110122);
        check(dout == 8'h33, "R4 three-frame last executed", dout, 8'h33);

        // R5: partial frames dropped
        xfer({49'h0, 15'h0077}, 15, -1, '0, rx);
        check(dout == 8'h33, "R5 15-bit frame dropped", dout, 8'h33);
        xfer({47'h0, 17'h00177}, 17, -1, '0, rx);
        check(dout == 8'h33, "R5 17-bit frame dropped", dout, 8'h33);
        c0 = sync_cnt;
        xfer({33'h0, 31'h0}, 31, -1, '0, rx);
        check(sync_cnt == c0 && dout == 8'h33, "R5 31-bit frame no action", dout, 8'h33);

        // R10: sync strobe
        c0 = sync_cnt;
        xfer({48'h0, 16'h10A5}, 16, -1, '0, rx);
        check(sync_cnt - c0 == 1, "R10 sync pulse lasts one cycle", sync_cnt - c0, 1);
        check(sync_last == 8'hA5, "R10 sync mask", sync_last, 8'hA5);

        // R9: change flags, read to clear
        xfer({48'h0, 16'h0300}, 16, -1, '0, rx);
        prev = din;
        din = 8'h0F;
        repeat (3) @(negedge clk);
        xfer({48'h0, 16'h0300}, 16, -1, '0, rx);
        check(rx[7:0] == (prev ^ 8'h0F), "R9 change flags first read", rx[7:0], prev ^ 8'h0F);
        din = 8'hF5;
        repeat (3) @(negedge clk);
        xfer({48'h0, 16'h0300}, 16, -1, '0, rx);
        check(rx[7:0] == 8'hFA, "R9 change flags accumulate", rx[7:0], 8'hFA);
        xfer({48'h0, 16'h0300}, 16, -1, '0, rx);
        check(rx[7:0] == 8'h00, "R9 flags cleared by read", rx[7:0], 0);

        // R8: quickstart with chip select held low
        rst_n = 1'b0;
        ncs = 1'b0;
        din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        while (cyc < W - 1) @(negedge clk);
        check(ready == 1'b0, "R8 not ready before window end", ready, 0);
        @(negedge clk);
        check(ready == 1'b1, "R8 ready right after window", ready, 1);
        ncs = 1'b1;
        repeat (2) @(negedge clk);
        xfer(64'h0, 16, -1, '0, rx);
        check(rx[15:8] == 8'hB0, "R8 both crc bits set", rx[15:8], 8'hB0);

        // R11: background load and busy
        xfer({48'h0, 16'h0500}, 16, -1, '0, rx);
        xfer(64'h0, 16, -1, '0, rx);
        check(rx[15:8] == 8'hF0, "R11 busy during load", rx[15:8], 8'hF0);
        repeat (L + 10) @(negedge clk);
        xfer(64'h0, 16, -1, '0, rx);
        check(rx[15:8] == 8'h80, "R11 busy and crc clear after load", rx[15:8], 8'h80);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule